// File: doc/BRIEF.md
# Interrupt-Stalled Serial Bus Byte Engine

This block is a byte-level engine for a two-wire open-drain serial bus (I2C/SMBus compatible). Software steers it through one 8-bit control/status register and one data register. Each wire has a drive-low output and a sampled input, so the pads and the wired-AND bus stay outside the block. In master mode the engine generates START, repeated START and STOP conditions. It shifts bytes out or in, most significant bit first, and it sends or captures the acknowledge bit that follows each byte.

After every bus event the engine sets its interrupt flag. While it is master it then holds the clock line low until software writes the flag back to 0. Each step of a transfer is therefore a handshake: software reads the status, loads or collects data, chooses the acknowledge answer, and clears the flag to start the next step. When the engine is not master it watches the bus for START and STOP conditions. During transmission it checks for arbitration loss. The clock comes from a fixed four-phase divider of the system clock.

Control/status bit map (bit 7 to bit 0): master, transmit-mode, start, stop, ack-request, arbitration-lost, ack, interrupt flag.

Top module: `smb_byte_engine`

## Requirements
- R1: After reset, all eight control/status bits read 0, the data register reads 0, the interrupt output is 0, and neither line is driven low.
- R2: A control write with start (bit 5) = 1 and interrupt flag (bit 0) = 0 generates a START: SDA falls while SCL is high. When the START is complete the control register reads 0xE1 (master, transmit, start, interrupt flag).
- R3: The interrupt output follows bit 0. Writing bit 0 = 1 forces an interrupt. While the flag is 1 and the engine is master in its stalled state, SCL is held low.
- R4: A transmitted byte goes out MSB first, with SDA changing only while SCL is low. The bit sampled in the following acknowledge slot is stored in bit 1 (SDA low = 1 = ACK, SDA high = 0 = NACK).
- R5: In the first byte after a START, bit 0 of the byte selects the direction. A value of 1 clears the transmit-mode bit (the engine becomes receiver); a value of 0 keeps it set.
- R6: In receive mode, clearing the flag shifts in 8 bits MSB first into the data register. The engine then stalls with ack-request (bit 3) = 1 before the acknowledge slot. On the next release it drives SDA low in that slot if bit 1 = 1 and leaves SDA released if bit 1 = 0, then receives the next byte.
- R7: Writing stop (bit 4) = 1 with the flag cleared makes the master send a STOP (SDA rises while SCL is high). If an acknowledge slot is pending, that slot is completed first. Afterwards master, transmit-mode and stop read 0, and no interrupt is raised.
- R8: If SDA is sampled low while the engine releases it for a 1 bit, arbitration is lost. The control register then reads 0x05, and both lines are released. Any control write that clears bit 0 also clears arbitration-lost.
- R9: When not master, a START seen on the bus sets bit 5 and bit 0, and a STOP seen on the bus sets bit 4 and bit 0.
- R10: A data register write is ignored while the interrupt flag is 0 and accepted while it is 1.
- R11: A START request made while already master produces a repeated START with no STOP in between, and the control register again reads 0xE1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control/status register |
| data_wr | input | 1 | Write strobe for the data register |
| wr_val | input | DW | Write value for either register |
| ctrl_q | output | 8 | Control/status register read value |
| data_q | output | DW | Data register read value |
| irq | output | 1 | Interrupt request (mirror of the flag) |
| scl_in | input | 1 | Sampled clock line |
| sda_in | input | 1 | Sampled data line |
| scl_drive_low | output | 1 | Pull the clock line low |
| sda_drive_low | output | 1 | Pull the data line low |

## Verification
The hardest case to reach from the ports is arbitration loss. It needs the far side of the bus to pull SDA low exactly when the engine releases it for a 1 bit. The bench models the bus as a wired AND with a small peer that counts SCL edges. After a START, the peer is switched to a mode that pulls SDA low in the first bit slot, and a byte with MSB 1 is sent into it. When the peer later releases SDA while SCL floats high, that release is also a bus STOP, which exercises slave-mode STOP detection. The byte paths are swept over all 256 values in both directions.

// File: rtl/smb_pkg.sv
// Shared definitions for the serial bus byte engine.
// Assumes an 8-bit control/status register with the bit positions below.
package smb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_ACK,
        ST_STOP
    } step_e;

    localparam int B_MST = 7;
    localparam int B_TXM = 6;
    localparam int B_STA = 5;
    localparam int B_STO = 4;
    localparam int B_ARQ = 3;
    localparam int B_ARB = 2;
    localparam int B_ACK = 1;
    localparam int B_SI  = 0;

endpackage

// File: rtl/smb_phase_gen.sv
// Four-phase bit timer. Each phase lasts PHASE_CYC system clocks.
// Assumes: run is held high for the whole duration of a bus step.
module smb_phase_gen #(
    parameter int PHASE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output logic [1:0] phase,
    output logic       tick
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count cycles inside a phase and advance the phase at its last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            phase <= 2'd0;
        end else if (tick) begin
            cnt   <= '0;
            phase <= phase + 2'd1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (!run || phase == ($past(phase) + 2'd1)));

endmodule

// File: rtl/smb_shifter.sv
// Shift register shared by transmit and receive, MSB first.
// Assumes the controller never asserts load and shift in the same cycle.
module smb_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] ld_val,
    input  logic             shift,
    input  logic             sin,
    output logic [WIDTH-1:0] q,
    output logic             msb
);
    assign msb = q[WIDTH-1];

    // Parallel load, or shift left with the new bit entering at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= ld_val;
        end else if (shift) begin
            q <= {q[WIDTH-2:0], sin};
        end
    end

endmodule

// File: rtl/smb_line_mon.sv
// Detects START (SDA falls, SCL high) and STOP (SDA rises, SCL high).
// Assumes the line inputs are already synchronous to clk.
module smb_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_seen,
    output logic stop_seen
);
    logic scl_q, sda_q;

    // Keep the previous line sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    assign start_seen = scl_q && scl_in && sda_q && !sda_in;
    assign stop_seen  = scl_q && scl_in && !sda_q && sda_in;

endmodule

// File: rtl/smb_byte_engine.sv
// Byte-level serial bus engine with an interrupt-flag stall after every
// bus event. Software writes the control register to request START/STOP,
// to pick the acknowledge answer and to clear the flag, which starts the
// next step. Assumes DW >= 8 (the control write uses wr_val[7:0]) and
// synchronous line inputs. No clock stretching by other devices.
module smb_byte_engine
    import smb_pkg::*;
#(
    parameter int PHASE_CYC = 2,
    parameter int DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          data_wr,
    input  logic [DW-1:0] wr_val,
    output logic [7:0]    ctrl_q,
    output logic [DW-1:0] data_q,
    output logic          irq,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_drive_low,
    output logic          sda_drive_low
);
    localparam int BCW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

    step_e          state;
    logic           mst, txm, sta, sto, arq, arb, ack, si;
    logic [DW-1:0]  dat;
    logic [BCW-1:0] bit_idx;
    logic           addr_phase, rx_dir, sda_hold;

    logic [1:0]     phase;
    logic           tick, run, t2, t3;
    logic [DW-1:0]  sh_q;
    logic           sh_msb, sh_load, sh_shift;
    logic           start_seen, stop_seen;
    logic           idle_go, go_start, go_ack, go_stop, go_byte;
    logic           scl_low_c, sda_low_c;

    assign run = (state != ST_IDLE);
    assign t2  = tick && (phase == 2'd2);
    assign t3  = tick && (phase == 2'd3);

    smb_phase_gen #(.PHASE_CYC(PHASE_CYC)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .phase(phase), .tick(tick)
    );

    smb_shifter #(.WIDTH(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .ld_val(dat),
        .shift(sh_shift), .sin(sda_in), .q(sh_q), .msb(sh_msb)
    );

    smb_line_mon u_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .start_seen(start_seen), .stop_seen(stop_seen)
    );

    // Decide which step to launch once software has released the stall.
    always_comb begin
        idle_go  = (state == ST_IDLE) && !si && !ctrl_wr;
        go_start = idle_go && sta;
        go_ack   = idle_go && !sta && mst && arq;
        go_stop  = idle_go && !sta && mst && !arq && sto;
        go_byte  = idle_go && !sta && mst && !arq && !sto;
        sh_load  = go_byte && txm;
        sh_shift = (state == ST_BIT) && (rx_dir ? t2 : t3);
    end

    // Line drive per step and phase; SDA only moves while SCL is low.
    always_comb begin
        scl_low_c = 1'b0;
        sda_low_c = 1'b0;
        unique case (state)
            ST_IDLE: begin
                scl_low_c = mst;
                sda_low_c = mst && sda_hold;
            end
            ST_START: begin
                scl_low_c = (phase == 2'd0) || (phase == 2'd3);
                sda_low_c = phase[1];
            end
            ST_BIT: begin
                scl_low_c = !phase[1];
                sda_low_c = (phase == 2'd0) ? sda_hold : (!rx_dir && !sh_msb);
            end
            ST_ACK: begin
                scl_low_c = !phase[1];
                sda_low_c = (phase == 2'd0) ? sda_hold : (rx_dir && ack);
            end
            ST_STOP: begin
                scl_low_c = !phase[1];
                sda_low_c = (phase == 2'd0) ? sda_hold : (phase != 2'd3);
            end
            default: begin
                scl_low_c = 1'b0;
                sda_low_c = 1'b0;
            end
        endcase
    end

    assign scl_drive_low = scl_low_c;
    assign sda_drive_low = sda_low_c;
    assign ctrl_q = {mst, txm, sta, sto, arq, arb, ack, si};
    assign data_q = dat;
    assign irq    = si;

    // Register file updates from software, then sequencing from hardware.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            mst        <= 1'b0;
            txm        <= 1'b0;
            sta        <= 1'b0;
            sto        <= 1'b0;
            arq        <= 1'b0;
            arb        <= 1'b0;
            ack        <= 1'b0;
            si         <= 1'b0;
            dat        <= '0;
            bit_idx    <= '0;
            addr_phase <= 1'b0;
            rx_dir     <= 1'b0;
            sda_hold   <= 1'b0;
        end else begin
            if (run) sda_hold <= sda_low_c;
            if (ctrl_wr) begin
                sta <= wr_val[B_STA];
                sto <= wr_val[B_STO];
                ack <= wr_val[B_ACK];
                si  <= wr_val[B_SI];
                if (!wr_val[B_SI]) arb <= 1'b0;
            end
            if (data_wr && si) dat <= wr_val;

            unique case (state)
                ST_IDLE: begin
                    if (go_start) begin
                        state <= ST_START;
                    end else if (go_ack) begin
                        state <= ST_ACK;
                    end else if (go_stop) begin
                        state <= ST_STOP;
                    end else if (go_byte) begin
                        state   <= ST_BIT;
                        bit_idx <= '0;
                        rx_dir  <= !txm;
                    end
                    if (!mst && start_seen) begin
                        sta <= 1'b1;
                        si  <= 1'b1;
                    end
                    if (!mst && stop_seen) begin
                        sto <= 1'b1;
                        si  <= 1'b1;
                    end
                end
                ST_START: begin
                    if (t3) begin
                        state      <= ST_IDLE;
                        mst        <= 1'b1;
                        txm        <= 1'b1;
                        sta        <= 1'b1;
                        si         <= 1'b1;
                        addr_phase <= 1'b1;
                    end
                end
                ST_BIT: begin
                    if (t2 && !rx_dir && sh_msb && !sda_in) begin
                        state      <= ST_IDLE;
                        arb        <= 1'b1;
                        mst        <= 1'b0;
                        txm        <= 1'b0;
                        si         <= 1'b1;
                        addr_phase <= 1'b0;
                        sda_hold   <= 1'b0;
                    end else if (t3) begin
                        if (bit_idx == LAST_BIT) begin
                            if (rx_dir) begin
                                state <= ST_IDLE;
                                dat   <= sh_q;
                                arq   <= 1'b1;
                                si    <= 1'b1;
                            end else begin
                                state <= ST_ACK;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (t2 && !rx_dir) ack <= !sda_in;
                    if (t3) begin
                        if (rx_dir) begin
                            arq <= 1'b0;
                            if (sto) begin
                                state <= ST_STOP;
                            end else begin
                                state   <= ST_BIT;
                                bit_idx <= '0;
                            end
                        end else begin
                            state <= ST_IDLE;
                            si    <= 1'b1;
                            if (addr_phase) begin
                                txm        <= !dat[0];
                                addr_phase <= 1'b0;
                            end
                        end
                    end
                end
                ST_STOP: begin
                    if (t3) begin
                        state    <= ST_IDLE;
                        sto      <= 1'b0;
                        mst      <= 1'b0;
                        txm      <= 1'b0;
                        sda_hold <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_scl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && mst && si) |=> scl_drive_low);

    assert_sda_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT && !scl_drive_low && $past(state == ST_BIT) && !$past(scl_drive_low))
        |-> $stable(sda_drive_low));

    assert_ackrq_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arq |-> (mst && !txm));

    assert_stop_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mst) && !arb) |-> (!sto && !txm));

    assert_arb_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb) |-> (!mst && !scl_drive_low && !sda_drive_low && si));

    assert_data_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && data_wr && !si) |=> $stable(dat));

endmodule

// File: tb/sim_smb_byte_engine.sv
`timescale 1ns/1ps
module sim_smb_byte_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] wr_val = 8'h00;
    logic [7:0] ctrl_q, data_q;
    logic       irq, scl_in, sda_in, scl_drive_low, sda_drive_low;

    // Peer model: 0 passive, 1 ack, 2 send peer_byte, 3 clash in bit 0, 4 pull low.
    int         peer_mode = 0;
    logic [7:0] peer_byte = 8'h00;
    int         bcnt = 9;
    logic       peer_low;
    logic [7:0] cap = 8'h00;
    logic       ack_seen = 1'b1;
    int         starts = 0;
    int         stops = 0;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    assign scl_in = !scl_drive_low;
    assign sda_in = !(sda_drive_low || peer_low);

    smb_byte_engine #(.PHASE_CYC(2), .DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .data_wr(data_wr),
        .wr_val(wr_val), .ctrl_q(ctrl_q), .data_q(data_q), .irq(irq),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    always_comb begin
        case (peer_mode)
            1:       peer_low = (bcnt == 8);
            2:       peer_low = (bcnt >= 0 && bcnt < 8) ? !peer_byte[7 - bcnt] : 1'b0;
            3:       peer_low = (bcnt == 0);
            4:       peer_low = 1'b1;
            default: peer_low = 1'b0;
        endcase
    end

    always @(negedge sda_in) if (scl_in === 1'b1) begin bcnt = -1; starts++; end
    always @(posedge sda_in) if (scl_in === 1'b1) stops++;
    always @(negedge scl_in) bcnt = (bcnt >= 8) ? 0 : bcnt + 1;
    always @(posedge scl_in) begin
        if (bcnt >= 0 && bcnt < 8) cap = {cap[6:0], sda_in};
        if (bcnt == 8) ack_seen = sda_in;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wctl(input logic [7:0] v);
        @(negedge clk); ctrl_wr = 1'b1; wr_val = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic wdat(input logic [7:0] v);
        @(negedge clk); data_wr = 1'b1; wr_val = v;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        logic got;
        got = 1'b0;
        for (int k = 0; k < 3000 && !got; k++) begin
            @(negedge clk);
            if (irq) got = 1'b1;
        end
        chk({req, " irq"}, {31'd0, got}, 32'd1);
    endtask

    task automatic wait_release(input string req);
        logic got;
        got = 1'b0;
        for (int k = 0; k < 3000 && !got; k++) begin
            @(negedge clk);
            if (!ctrl_q[7]) got = 1'b1;
        end
        repeat (4) @(negedge clk);
        chk({req, " master drop"}, {31'd0, got}, 32'd1);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        int s0;
        int p0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1; starts = 0; stops = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", ctrl_q, 8'h00);
        chk("R1 data", data_q, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 lines", {scl_drive_low, sda_drive_low}, 2'b00);
        // R10 data write ignored with flag clear
        wdat(8'hA5);
        chk("R10 ignored", data_q, 8'h00);
        // R3 forced interrupt, R10 accepted while flagged
        wctl(8'h01);
        chk("R3 forced ctrl", ctrl_q, 8'h01);
        chk("R3 forced irq", irq, 1'b1);
        wdat(8'h5A);
        chk("R10 accepted", data_q, 8'h5A);
        wctl(8'h00);
        repeat (20) @(negedge clk);
        chk("R3 cleared idle", {ctrl_q, scl_drive_low}, 9'h000);

        // R2 START then R4/R5 address write
        peer_mode = 1;
        wctl(8'h20); wait_irq("R2");
        chk("R2 ctrl", ctrl_q, 8'hE1);
        chk("R2 start seen", starts, 1);
        repeat (10) @(negedge clk);
        chk("R3 scl held", {scl_drive_low, irq}, 2'b11);
        wdat(8'hA4); wctl(8'h00); wait_irq("R5");
        chk("R4 addr bits", cap, 8'hA4);
        chk("R5 stays tx", ctrl_q, 8'hC3);
        for (int v = 0; v < 256; v++) begin
            wdat(v[7:0]); wctl(8'h00); wait_irq("R4");
            chk("R4 tx byte", cap, v[7:0]);
            chk("R4 tx ack", ctrl_q, 8'hC3);
        end
        peer_mode = 0;
        wdat(8'h3C); wctl(8'h00); wait_irq("R4");
        chk("R4 nack", ctrl_q, 8'hC1);
        // R7 STOP from transmit
        wctl(8'h10); wait_release("R7");
        chk("R7 ctrl", ctrl_q, 8'h00);
        chk("R7 stop seen", stops, 1);
        chk("R7 lines", {scl_drive_low, sda_drive_low, irq}, 3'b000);

        // R5/R6 read transaction
        peer_mode = 1;
        wctl(8'h20); wait_irq("R2");
        wdat(8'hA5); wctl(8'h00); wait_irq("R5");
        chk("R5 to rx", ctrl_q, 8'h83);
        peer_mode = 2;
        for (int v = 0; v < 256; v++) begin
            peer_byte = v[7:0];
            wctl((v == 0) ? 8'h00 : 8'h02); wait_irq("R6");
            chk("R6 rx data", data_q, v[7:0]);
            chk("R6 ackrq", ctrl_q, (v == 0) ? 8'h89 : 8'h8B);
            if (v > 0) chk("R6 ack driven", ack_seen, 1'b0);
        end
        wctl(8'h10); wait_release("R7");
        chk("R7 nack before stop", ack_seen, 1'b1);
        chk("R7 rx stop ctrl", ctrl_q, 8'h00);
        chk("R7 rx stop seen", stops, 2);

        // R11 repeated START
        peer_mode = 1;
        wctl(8'h20); wait_irq("R11");
        wdat(8'h50); wctl(8'h00); wait_irq("R11");
        chk("R11 pre", ctrl_q, 8'hC3);
        s0 = starts; p0 = stops;
        wctl(8'h20); wait_irq("R11");
        chk("R11 restart", starts, s0 + 1);
        chk("R11 no stop", stops, p0);
        chk("R11 ctrl", ctrl_q, 8'hE1);
        wdat(8'h51); wctl(8'h00); wait_irq("R11");
        chk("R11 rx addr", ctrl_q, 8'h83);
        wctl(8'h10); wait_release("R7");
        chk("R7 after restart", ctrl_q, 8'h00);

        // R8 arbitration loss, then R9 STOP detection on release
        wctl(8'h20); wait_irq("R8");
        peer_mode = 3;
        wdat(8'h80); wctl(8'h00); wait_irq("R8");
        chk("R8 ctrl", ctrl_q, 8'h05);
        chk("R8 lines", {scl_drive_low, sda_drive_low}, 2'b00);
        peer_mode = 0;
        repeat (3) @(negedge clk);
        chk("R9 stop detect", ctrl_q, 8'h15);
        wctl(8'h00);
        chk("R8 arb cleared", ctrl_q, 8'h00);

        // R9 START detection from another device
        peer_mode = 4;
        repeat (3) @(negedge clk);
        chk("R9 start detect", ctrl_q, 8'h21);
        peer_mode = 0;
        repeat (3) @(negedge clk);
        chk("R9 stop after start", ctrl_q, 8'h31);
        wctl(8'h00);
        chk("R9 cleared", ctrl_q, 8'h00);

        summary();
    end
endmodule